// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the shifting datapath behind rotate-left-then-mask integer operations. One operation carries a 64-bit source, a shift count, two mask indices and a two-bit mode. The source is rotated left (or shifted left with zero fill). In parallel a mask is built from the two indices, and the block returns the shifted value, the mask and their bitwise AND. Bit positions in the indices count from the most significant end, so index 0 names the top bit of the word.

In word modes the low half of the source is copied into both halves before a full-width rotate, so that the rotated low half is the correct 32-bit rotate. Both mask indices then address the low half of the word. When the begin index lies past the end index, the mask wraps around the word instead of coming out empty.

Operations enter on a valid/ready stream and leave on a second valid/ready stream through one output register. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its contents unchanged and no new operation is taken. The output register can be emptied and refilled in the same cycle.

Top module: `rotmask_unit`

## Requirements
- R1: Index k names bit 63-k of a 64-bit vector. When the effective begin index is not greater than the effective end index, `out_mask` is one exactly at the indices from begin to end, both included.
- R2: When the effective begin index is greater than the effective end index, `out_mask` is one everywhere except at the indices strictly between end and begin, which are zero.
- R3: With `in_mode` = 2'b00 (doubleword rotate), `out_rot` is `in_src` rotated left by `in_amt` (0 to 63). Rotating 0xdeadbeef12345678 by 10 gives 0xb6fbbc48d159e37a, and by 35 gives 0x91a2b3c6f56df778.
- R4: When `in_mode[0]` = 1 (word modes), the shifter input is {`in_src[31:0]`, `in_src[31:0]`}. The effective begin and end indices are 32 plus bits [4:0] of `in_mb` and `in_me`, and bit 5 of each index is ignored. In mode 2'b01, rotating low word 0xdeadbeef by 10 puts 0xb6fbbf7a in both halves of `out_rot`.
- R5: When `in_mode[1]` = 1 (shift-only modes: 2'b10 doubleword, 2'b11 word), `out_rot` is the shifter input shifted left by `in_amt` with the vacated low bits set to zero.
- R6: `out_result` always equals `out_rot & out_mask`.
- R7: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the outputs, with `out_valid` high, just after that edge.
- R8: `in_ready` is `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R9: During reset (`rst_n` low, asynchronous), `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The operation is taken this cycle |
| in_src | input | 64 | Source value |
| in_amt | input | 6 | Shift or rotate count |
| in_mb | input | 6 | Mask begin index (0 = most significant bit) |
| in_me | input | 6 | Mask end index |
| in_mode | input | 2 | Bit 0: word mode; bit 1: shift-only mode |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_rot | output | 64 | Rotated or shifted value |
| out_mask | output | 64 | Generated mask |
| out_result | output | 64 | Rotated value ANDed with the mask |

## Verification
Some properties are checked on every cycle: the one-cycle latency, hold under back-pressure, the AND of the two outputs, and the population count of the mask for both plain and wrapped doubleword ranges. Also checked every cycle are zero fill in shift-only modes and the equal halves of a word rotate. Several things can only be shown by the bench's scenarios against its own model: the exact bit placement of each mask, the rotated values for known operands, the offset of word-mode indices (including that their top bit is ignored), and the refill of the output register in the same cycle it drains.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic [1:0] {
    RM_DROT = 2'b00,
    RM_WROT = 2'b01,
    RM_DSHL = 2'b10,
    RM_WSHL = 2'b11
  } rm_mode_e;

  function automatic logic mode_is_word(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_is_shift(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/rm_operand_prep.sv
module rm_operand_prep #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic              word_mode,
  input  logic [IDX_W-1:0]  mb_raw,
  input  logic [IDX_W-1:0]  me_raw,
  output logic [DATA_W-1:0] shift_in,
  output logic [IDX_W-1:0]  mb_eff,
  output logic [IDX_W-1:0]  me_eff
);
  logic [HALF_W-1:0] low_half;
  assign low_half = src[HALF_W-1:0];

  always_comb begin
    if (word_mode) begin
      shift_in = {low_half, low_half};
      mb_eff   = {1'b1, mb_raw[IDX_W-2:0]};
      me_eff   = {1'b1, me_raw[IDX_W-2:0]};
    end else begin
      shift_in = src;
      mb_eff   = mb_raw;
      me_eff   = me_raw;
    end
  end
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  amt,
  input  logic              zero_fill,
  output logic [DATA_W-1:0] dout
);
  logic [IDX_W:0][DATA_W-1:0] stage;

  assign stage[0] = din;

  for (genvar s = 0; s < IDX_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    logic [DATA_W-1:0] up;
    logic [DATA_W-1:0] wrap_in;
    assign up      = stage[s] << DIST;
    assign wrap_in = zero_fill ? '0 : (stage[s] >> (DATA_W - DIST));
    assign stage[s+1] = amt[s] ? (up | wrap_in) : stage[s];
  end

  assign dout = stage[IDX_W];
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  mb,
  input  logic [IDX_W-1:0]  me,
  output logic [DATA_W-1:0] mask
);
  logic wraps;
  assign wraps = mb > me;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(k);
    logic at_or_after_b;
    logic at_or_before_e;
    assign at_or_after_b  = POS >= mb;
    assign at_or_before_e = POS <= me;
    assign mask[DATA_W-1-k] = wraps ? (at_or_after_b | at_or_before_e)
                                    : (at_or_after_b & at_or_before_e);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_src,
  input  logic [IDX_W-1:0]  in_amt,
  input  logic [IDX_W-1:0]  in_mb,
  input  logic [IDX_W-1:0]  in_me,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_rot,
  output logic [DATA_W-1:0] out_mask,
  output logic [DATA_W-1:0] out_result
);
  logic [DATA_W-1:0] shift_in;
  logic [IDX_W-1:0]  mb_eff;
  logic [IDX_W-1:0]  me_eff;
  logic [DATA_W-1:0] rot_c;
  logic [DATA_W-1:0] mask_c;
  logic              take;

  rm_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .src      (in_src),
    .word_mode(mode_is_word(in_mode)),
    .mb_raw   (in_mb),
    .me_raw   (in_me),
    .shift_in (shift_in),
    .mb_eff   (mb_eff),
    .me_eff   (me_eff)
  );

  rm_rotator #(.DATA_W(DATA_W)) u_rot (
    .din      (shift_in),
    .amt      (in_amt),
    .zero_fill(mode_is_shift(in_mode)),
    .dout     (rot_c)
  );

  rm_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .mb  (mb_eff),
    .me  (me_eff),
    .mask(mask_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_rot    <= '0;
      out_mask   <= '0;
      out_result <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_rot    <= rot_c;
        out_mask   <= mask_c;
        out_result <= rot_c & mask_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rotmask_checker.sv
module rotmask_checker #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  in_amt,
  input logic [IDX_W-1:0]  in_mb,
  input logic [IDX_W-1:0]  in_me,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_rot,
  input logic [DATA_W-1:0] out_mask,
  input logic [DATA_W-1:0] out_result
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rot)
                                && $stable(out_mask) && $stable(out_result));

  assert_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result == (out_rot & out_mask));

  assert_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_mode[0] && (in_mb <= in_me) |=>
      $countones(out_mask) == (int'($past(in_me)) - int'($past(in_mb)) + 1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_mode[0] && (in_mb > in_me) |=>
      $countones(out_mask) == (DATA_W - (int'($past(in_mb)) - int'($past(in_me)) - 1)));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode[1] |=> (out_rot << (DATA_W - int'($past(in_amt)))) == '0);

  assert_word_halves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_mode == 2'b01) |=> out_rot[DATA_W-1:HALF_W] == out_rot[HALF_W-1:0]);

  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind rotmask_unit rotmask_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_amt    (in_amt),
  .in_mb     (in_mb),
  .in_me     (in_me),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rot   (out_rot),
  .out_mask  (out_mask),
  .out_result(out_result)
);

// File: tb/tb_rotmask_unit.sv
`timescale 1ns/1ps
module tb_rotmask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [5:0]  in_amt = '0;
  logic [5:0]  in_mb = '0;
  logic [5:0]  in_me = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_rot;
  logic [63:0] out_mask;
  logic [63:0] out_result;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rotmask_unit dut (.*);

  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++) begin
      if (b <= e) m[63-k] = (k >= b) && (k <= e);
      else        m[63-k] = (k >= b) || (k <= e);
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_rotl(input logic [63:0] v, input int n);
    n = n % 64;
    if (n == 0) return v;
    return (v << n) | (v >> (64 - n));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] s, input int a, input int b, input int e,
                       input logic [1:0] m);
    in_src = s; in_amt = 6'(a); in_mb = 6'(b); in_me = 6'(e); in_mode = m;
  endtask

  // one transaction with the consumer always ready; sampled at the following negedge
  task automatic run_op(input string tag, input logic [63:0] s, input int a,
                        input int b, input int e, input logic [1:0] m,
                        input logic [63:0] exp_rot, input logic [63:0] exp_mask);
    @(negedge clk);
    drive(s, a, b, e, m);
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R7 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " rot"}, out_rot, exp_rot);
    chk({tag, " mask"}, out_mask, exp_mask);
    chk({tag, " R6 result"}, out_result, exp_rot & exp_mask);
  endtask

  task automatic t_reset();
    chk("R9 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R9 in_ready in reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_dword_rotate();
    run_op("R3 rot10", 64'hdeadbeef12345678, 10, 0, 63, 2'b00,
           64'hb6fbbc48d159e37a, 64'hffffffffffffffff);
    run_op("R3 rot35", 64'hdeadbeef12345678, 35, 0, 63, 2'b00,
           64'h91a2b3c6f56df778, 64'hffffffffffffffff);
    run_op("R3 rot0", 64'h0123456789abcdef, 0, 0, 63, 2'b00,
           64'h0123456789abcdef, 64'hffffffffffffffff);
  endtask

  task automatic t_masks();
    run_op("R1 mask37_63", 64'hffffffffffffffff, 0, 37, 63, 2'b00,
           64'hffffffffffffffff, 64'h0000000007ffffff);
    run_op("R1 mask0_37", 64'hffffffffffffffff, 0, 0, 37, 2'b00,
           64'hffffffffffffffff, 64'hfffffffffc000000);
    run_op("R1 mask5_5", 64'h1, 1, 5, 5, 2'b00,
           64'h2, ref_mask(5, 5));
    run_op("R2 wrap 50_3", 64'hfedcba9876543210, 7, 50, 3, 2'b00,
           ref_rotl(64'hfedcba9876543210, 7), ref_mask(50, 3));
  endtask

  task automatic t_word_modes();
    // word mode: indices offset by 32, giving 47,37 and 62,34 and 32,32
    run_op("R2 R4 wmask47_37", 64'hffffffffffffffff, 0, 15, 5, 2'b01,
           64'hffffffffffffffff, 64'hfffffffffc01ffff);
    run_op("R2 R4 wmask62_34", 64'hffffffffffffffff, 0, 30, 2, 2'b01,
           64'hffffffffffffffff, 64'hffffffffe0000003);
    run_op("R1 R4 wmask32_32", 64'hffffffffffffffff, 0, 0, 0, 2'b01,
           64'hffffffffffffffff, 64'h0000000080000000);
    run_op("R4 wrot10", 64'h55555555deadbeef, 10, 0, 31, 2'b01,
           64'hb6fbbf7ab6fbbf7a, 64'h00000000ffffffff);
    // index bit 5 is ignored in word mode: 32 behaves as 0
    run_op("R4 ignore idx bit5", 64'h00000000deadbeef, 17, 32, 63, 2'b01,
           ref_rotl(64'hdeadbeefdeadbeef, 17), 64'h00000000ffffffff);
  endtask

  task automatic t_shift_only();
    run_op("R5 dshl4", 64'hdeadbeef12345678, 4, 0, 63, 2'b10,
           64'headbeef123456780, 64'hffffffffffffffff);
    run_op("R5 dshl63", 64'h0000000000000003, 63, 0, 63, 2'b10,
           64'h8000000000000000, 64'hffffffffffffffff);
    run_op("R5 R4 wshl8", 64'h12345678deadbeef, 8, 0, 31, 2'b11,
           64'hadbeefdeadbeef00, 64'h00000000ffffffff);
  endtask

  task automatic t_backpressure();
    logic [63:0] ra, rb;
    ra = ref_rotl(64'h0f0f0f0f0f0f0f0f, 3);
    rb = ref_rotl(64'h123456789abcdef0, 12);
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h0f0f0f0f0f0f0f0f, 3, 0, 63, 2'b00);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(64'h123456789abcdef0, 12, 8, 55, 2'b00);
    chk("R8 in_ready low when full", 64'(in_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 held valid", 64'(out_valid), 64'd1);
    chk("R8 held rot", out_rot, ra);
    chk("R8 held result", out_result, ra);
    chk("R8 in_ready follows out_ready", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready with drain", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 refill valid", 64'(out_valid), 64'd1);
    chk("R8 refill rot", out_rot, rb);
    chk("R8 refill mask", out_mask, ref_mask(8, 55));
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'(out_valid), 64'd0);
    t_dword_rotate();
    t_masks();
    t_word_modes();
    t_shift_only();
    t_backpressure();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule